// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits between a processor-side write path and the storage backend of a parallel flash device. It watches each write strobe with its address and data byte, and recognises the multi-cycle unlock protocol. A key pair of writes is followed by a command byte. For erase commands, a second key pair and a second command byte follow. The block turns each complete, legal sequence into a one-cycle request. The backend acts on that request: it stores a byte, loads a page buffer, commits a page, erases a sector or the whole array, or switches the read path into or out of identification mode.

The parameter `PAGE_VARIANT` selects the device flavour. With `PAGE_VARIANT = 0` (sector variant), the block programs single bytes, supports 4 KB sector erase, and accepts a lone 0xF0 write to leave identification mode. With `PAGE_VARIANT = 1` (page variant), a program command opens a page load. That load collects bytes within one page until the page is full or until a quiet period expires, and then commits the page. This variant also has software data protection. Protection is on after reset; while it is off, a plain write in idle opens a page load with no unlock sequence.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `id_mode` is 0, no request is active and software data protection is on, so on the page variant a plain idle write that does not match the first key produces no request.
- R2: Key matching looks only at address bits [14:0]. The first cycle must be 0x5555 with data 0xAA, the second 0x2AAA with data 0x55, and the command cycle must be at 0x5555. Any mismatch returns to idle without a request.
- R3: A command byte 0x90 sets `id_mode` and pulses `id_enter_req`. A command byte 0xF0 clears `id_mode` and pulses `id_exit_req`.
- R4: Command 0x80 opens a second key-pair-plus-command run. A second command of 0x10 pulses `chip_erase_req` on both variants.
- R5: A second command of 0x30 on the sector variant pulses `sect_erase_req` with `req_addr` equal to the sixth-cycle address with bits [11:0] cleared. On the page variant it produces no request.
- R6: A second command of 0x60 sets `id_mode` and pulses `id_enter_req`. No other event changes `id_mode`.
- R7: A second command of 0x20 on the page variant pulses `sdp_off_req` and turns protection off. On the sector variant it has no effect.
- R8: On the sector variant, any idle write with data 0xF0 pulses `id_exit_req` and clears `id_mode`, with no key pair.
- R9: On the sector variant, after command 0xA0 the next write pulses `prog_req` with that write's address and data, and the sequencer returns to idle.
- R10: On the page variant, the first write after 0xA0 opens a page load. The page base is that address with bits [log2(PAGE_BYTES)-1:0] cleared. Every write within that page pulses `prog_req`; writes to other pages are ignored and do not restart the quiet timer.
- R11: A page load commits through `page_commit_req` with `page_addr` equal to the base. The commit comes in the same cycle as the `prog_req` of the write that fills the page, or `TIMEOUT` cycles after the last accepted write. A write accepted on the expiring cycle restarts the timer instead.
- R12: On the page variant with protection off, an idle write that does not match the first key opens a page load as its first byte.
- R13: Every request appears in the cycle after the clock edge that sampled the write causing it. At most one of the requests other than `page_commit_req` is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| prog_req | output | 1 | Store one byte (sector) or load one page byte (page) |
| chip_erase_req | output | 1 | Erase whole array |
| sect_erase_req | output | 1 | Erase the 4 KB sector at `req_addr` |
| id_enter_req | output | 1 | Identification mode entered |
| id_exit_req | output | 1 | Identification mode left |
| sdp_off_req | output | 1 | Software data protection switched off |
| page_commit_req | output | 1 | Write the loaded page at `page_addr` |
| req_addr | output | ADDR_W | Address carried by the current request |
| req_data | output | 8 | Data carried by the current request |
| page_addr | output | ADDR_W | Base of the page being loaded |
| id_mode | output | 1 | Identification mode flag |

## Verification
On the page variant, the write that fills a page produces `prog_req` and `page_commit_req` in the same cycle. The backend must load the byte before the page is written back. The bench fills a page with exactly `PAGE_BYTES` in-page writes and expects both pulses together, with the last byte's address on `req_addr` and the base on `page_addr`. A related edge case is a write that lands on the cycle in which the quiet timer would expire. The bench times a write onto exactly that cycle and expects a byte load with no commit, then a commit a full `TIMEOUT` later. Both variants are run side by side on the same random and directed stream, and each is compared with a per-variant reference model.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CYC2, ST_CYC3, ST_CYC4, ST_CYC5, ST_CYC6, ST_DATA, ST_PAGE
  } seq_state_t;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;

  localparam logic [7:0] CMD_ERASE_PFX = 8'h80;
  localparam logic [7:0] CMD_PROG      = 8'hA0;
  localparam logic [7:0] CMD_ID_ENTER  = 8'h90;
  localparam logic [7:0] CMD_ID_EXIT   = 8'hF0;
  localparam logic [7:0] CMD_CHIP      = 8'h10;
  localparam logic [7:0] CMD_SECTOR    = 8'h30;
  localparam logic [7:0] CMD_ID_ALT    = 8'h60;
  localparam logic [7:0] CMD_SDP_OFF   = 8'h20;

  function automatic logic is_key_a(input logic [14:0] a, input logic [7:0] d);
    return (a == KEY_ADDR_A) && (d == KEY_DATA_A);
  endfunction

  function automatic logic is_key_b(input logic [14:0] a, input logic [7:0] d);
    return (a == KEY_ADDR_B) && (d == KEY_DATA_B);
  endfunction
endpackage

// File: rtl/fsq_match.sv
module fsq_match
  import fsq_pkg::*;
(
  input  logic [14:0] addr_lo,
  input  logic [7:0]  data,
  output logic        key_a_o,
  output logic        key_b_o,
  output logic        cmd_addr_o
);
  assign key_a_o    = is_key_a(addr_lo, data);
  assign key_b_o    = is_key_b(addr_lo, data);
  assign cmd_addr_o = (addr_lo == KEY_ADDR_A);
endmodule

// File: rtl/fsq_page_track.sv
module fsq_page_track #(
  parameter int PG_W       = 11,
  parameter int PAGE_BYTES = 128,
  parameter int TIMEOUT    = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            accept_i,
  input  logic            active_i,
  input  logic [PG_W-1:0] page_i,
  output logic [PG_W-1:0] base_o,
  output logic            in_page_o,
  output logic            last_o,
  output logic            expire_o
);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam int TMR_W = $clog2(TIMEOUT + 1);

  logic [PG_W-1:0]  base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] tmr_q;

  assign base_o    = base_q;
  assign in_page_o = (page_i == base_q);
  assign last_o    = accept_i && (cnt_q == CNT_W'(PAGE_BYTES - 1));
  assign expire_o  = active_i && !accept_i && (tmr_q == TMR_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      tmr_q  <= '0;
    end else if (start_i) begin
      base_q <= page_i;
      cnt_q  <= CNT_W'(1);
      tmr_q  <= '0;
    end else if (accept_i) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tmr_q  <= '0;
    end else if (active_i) begin
      tmr_q  <= tmr_q + TMR_W'(1);
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fsq_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter bit PAGE_VARIANT = 1'b0,
  parameter int PAGE_BYTES   = 128,
  parameter int TIMEOUT      = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              prog_req,
  output logic              chip_erase_req,
  output logic              sect_erase_req,
  output logic              id_enter_req,
  output logic              id_exit_req,
  output logic              sdp_off_req,
  output logic              page_commit_req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data,
  output logic [ADDR_W-1:0] page_addr,
  output logic              id_mode
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int SECT_W = 12;

  function automatic logic [ADDR_W-1:0] sector_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:SECT_W], SECT_W'(0)};
  endfunction

  seq_state_t st_q, st_d;
  logic id_q, id_d, sdp_q, sdp_d;
  logic n_prog, n_chip, n_sect, n_iden, n_idex, n_sdp, n_commit;
  logic prog_q, chip_q, sect_q, iden_q, idex_q, sdpr_q, commit_q;
  logic [ADDR_W-1:0] raddr_d, raddr_q;
  logic [7:0]        rdata_q;

  // named internal events
  logic ev_key_a, ev_key_b, ev_cmd_addr;
  logic page_start, page_accept, page_last, page_expire, in_page;
  logic [PG_W-1:0] page_base;

  fsq_match u_match (
    .addr_lo   (wr_addr[14:0]),
    .data      (wr_data),
    .key_a_o   (ev_key_a),
    .key_b_o   (ev_key_b),
    .cmd_addr_o(ev_cmd_addr)
  );

  assign page_accept = (st_q == ST_PAGE) && wr_en && in_page;
  assign page_start  = PAGE_VARIANT && wr_en &&
                       ((st_q == ST_DATA) || ((st_q == ST_IDLE) && !sdp_q && !ev_key_a));

  fsq_page_track #(.PG_W(PG_W), .PAGE_BYTES(PAGE_BYTES), .TIMEOUT(TIMEOUT)) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (page_start),
    .accept_i (page_accept),
    .active_i (st_q == ST_PAGE),
    .page_i   (wr_addr[ADDR_W-1:PAGE_W]),
    .base_o   (page_base),
    .in_page_o(in_page),
    .last_o   (page_last),
    .expire_o (page_expire)
  );

  always_comb begin
    st_d = st_q;  id_d = id_q;  sdp_d = sdp_q;
    n_prog = 1'b0; n_chip = 1'b0; n_sect = 1'b0; n_iden = 1'b0;
    n_idex = 1'b0; n_sdp = 1'b0; n_commit = 1'b0;
    raddr_d = wr_addr;
    unique case (st_q)
      ST_IDLE: if (wr_en) begin
        if (!PAGE_VARIANT && wr_data == CMD_ID_EXIT) begin
          n_idex = 1'b1; id_d = 1'b0;
        end else if (ev_key_a) begin
          st_d = ST_CYC2;
        end else if (page_start) begin
          n_prog = 1'b1; st_d = ST_PAGE;
        end
      end
      ST_CYC2: if (wr_en) st_d = ev_key_b ? ST_CYC3 : ST_IDLE;
      ST_CYC4: if (wr_en) st_d = ev_key_a ? ST_CYC5 : ST_IDLE;
      ST_CYC5: if (wr_en) st_d = ev_key_b ? ST_CYC6 : ST_IDLE;
      ST_CYC3: if (wr_en) begin
        st_d = ST_IDLE;
        if (ev_cmd_addr) begin
          case (wr_data)
            CMD_ERASE_PFX: st_d = ST_CYC4;
            CMD_PROG:      st_d = ST_DATA;
            CMD_ID_ENTER:  begin n_iden = 1'b1; id_d = 1'b1; end
            CMD_ID_EXIT:   begin n_idex = 1'b1; id_d = 1'b0; end
            default:       ;
          endcase
        end
      end
      ST_CYC6: if (wr_en) begin
        st_d = ST_IDLE;
        if (ev_cmd_addr) begin
          case (wr_data)
            CMD_CHIP:    n_chip = 1'b1;
            CMD_SECTOR:  if (!PAGE_VARIANT) begin
                           n_sect = 1'b1; raddr_d = sector_base(wr_addr);
                         end
            CMD_ID_ALT:  begin n_iden = 1'b1; id_d = 1'b1; end
            CMD_SDP_OFF: if (PAGE_VARIANT) begin n_sdp = 1'b1; sdp_d = 1'b0; end
            default:     ;
          endcase
        end
      end
      ST_DATA: if (wr_en) begin
        n_prog = 1'b1;
        st_d   = PAGE_VARIANT ? ST_PAGE : ST_IDLE;
      end
      ST_PAGE: begin
        if (page_accept) begin
          n_prog = 1'b1;
          if (page_last) begin n_commit = 1'b1; st_d = ST_IDLE; end
        end else if (page_expire) begin
          n_commit = 1'b1; st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; id_q <= 1'b0; sdp_q <= 1'b1;
      prog_q <= 1'b0; chip_q <= 1'b0; sect_q <= 1'b0; iden_q <= 1'b0;
      idex_q <= 1'b0; sdpr_q <= 1'b0; commit_q <= 1'b0;
      raddr_q <= '0; rdata_q <= '0;
    end else begin
      st_q <= st_d; id_q <= id_d; sdp_q <= sdp_d;
      prog_q <= n_prog; chip_q <= n_chip; sect_q <= n_sect; iden_q <= n_iden;
      idex_q <= n_idex; sdpr_q <= n_sdp; commit_q <= n_commit;
      if (wr_en) begin
        raddr_q <= raddr_d;
        rdata_q <= wr_data;
      end
    end
  end

  assign prog_req        = prog_q;
  assign chip_erase_req  = chip_q;
  assign sect_erase_req  = sect_q;
  assign id_enter_req    = iden_q;
  assign id_exit_req     = idex_q;
  assign sdp_off_req     = sdpr_q;
  assign page_commit_req = commit_q;
  assign req_addr        = raddr_q;
  assign req_data        = rdata_q;
  assign page_addr       = {page_base, PAGE_W'(0)};
  assign id_mode         = id_q;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W     = 18,
  parameter int PAGE_BYTES = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              prog_req,
  input logic              chip_erase_req,
  input logic              sect_erase_req,
  input logic              id_enter_req,
  input logic              id_exit_req,
  input logic              sdp_off_req,
  input logic              page_commit_req,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] page_addr,
  input logic              id_mode
);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'(12'hFFF);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_erase_req, sect_erase_req, id_enter_req, id_exit_req, sdp_off_req})); // R13
  AST_REQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || chip_erase_req || sect_erase_req || id_enter_req || id_exit_req || sdp_off_req)
      |-> $past(wr_en)); // R13
  AST_ID_ENTER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter_req |-> id_mode); // R3
  AST_ID_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit_req |-> !id_mode); // R8
  AST_ID_ONLY_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_mode) |-> (id_enter_req || id_exit_req)); // R6
  AST_SECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    sect_erase_req |-> ((req_addr & SECT_MASK) == '0)); // R5
  AST_COMMIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    page_commit_req |-> ((page_addr & PAGE_MASK) == '0)); // R10
  AST_CHIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_req |=> !chip_erase_req); // R4
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    page_commit_req |=> !page_commit_req); // R11
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (.*);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  localparam int AW = 18, PB = 8, PW = 3, TO = 16;
  localparam int P_PROG = 6, P_CHIP = 5, P_SECT = 4, P_IDEN = 3, P_IDEX = 2, P_SDP = 1, P_COMMIT = 0;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  always #4 clk = ~clk;

  logic [6:0] g_pulse [2];
  logic [AW-1:0] g_raddr [2], g_paddr [2];
  logic [7:0] g_rdata [2];
  logic g_id [2];

  flash_cmd_seq #(.ADDR_W(AW), .PAGE_VARIANT(1'b0), .PAGE_BYTES(PB), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_req(g_pulse[0][P_PROG]), .chip_erase_req(g_pulse[0][P_CHIP]),
    .sect_erase_req(g_pulse[0][P_SECT]), .id_enter_req(g_pulse[0][P_IDEN]),
    .id_exit_req(g_pulse[0][P_IDEX]), .sdp_off_req(g_pulse[0][P_SDP]),
    .page_commit_req(g_pulse[0][P_COMMIT]), .req_addr(g_raddr[0]), .req_data(g_rdata[0]),
    .page_addr(g_paddr[0]), .id_mode(g_id[0]));

  flash_cmd_seq #(.ADDR_W(AW), .PAGE_VARIANT(1'b1), .PAGE_BYTES(PB), .TIMEOUT(TO)) u_dut_pw (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_req(g_pulse[1][P_PROG]), .chip_erase_req(g_pulse[1][P_CHIP]),
    .sect_erase_req(g_pulse[1][P_SECT]), .id_enter_req(g_pulse[1][P_IDEN]),
    .id_exit_req(g_pulse[1][P_IDEX]), .sdp_off_req(g_pulse[1][P_SDP]),
    .page_commit_req(g_pulse[1][P_COMMIT]), .req_addr(g_raddr[1]), .req_data(g_rdata[1]),
    .page_addr(g_paddr[1]), .id_mode(g_id[1]));

  int n_vec = 0, n_bad = 0;
  int m_st[2], m_id[2], m_sdp[2], m_base[2], m_cnt[2], m_tmr[2];
  logic [6:0] e_pulse [2];
  int e_addr[2], e_data[2];
  string e_tag[2];

  task automatic model_step(input int v, input bit we, input int a, input int d);
    int lo = a & 'h7fff;
    bit pv = (v == 1);
    bit acc;
    e_pulse[v] = '0; e_addr[v] = a; e_data[v] = d; e_tag[v] = "R2";
    case (m_st[v])
      0: if (we) begin
        if (!pv && d == 'hF0) begin e_pulse[v][P_IDEX] = 1; m_id[v] = 0; e_tag[v] = "R8"; end
        else if (lo == 'h5555 && d == 'hAA) m_st[v] = 1;
        else if (pv && m_sdp[v] == 0) begin
          m_base[v] = a & ~(PB - 1); m_cnt[v] = 1; m_tmr[v] = 0;
          e_pulse[v][P_PROG] = 1; m_st[v] = 7; e_tag[v] = "R12";
        end else e_tag[v] = "R1";
      end
      1: if (we) m_st[v] = (lo == 'h2AAA && d == 'h55) ? 2 : 0;
      3: if (we) m_st[v] = (lo == 'h5555 && d == 'hAA) ? 4 : 0;
      4: if (we) m_st[v] = (lo == 'h2AAA && d == 'h55) ? 5 : 0;
      2: if (we) begin
        m_st[v] = 0;
        if (lo == 'h5555) case (d)
          'h80: m_st[v] = 3;
          'hA0: m_st[v] = 6;
          'h90: begin e_pulse[v][P_IDEN] = 1; m_id[v] = 1; e_tag[v] = "R3"; end
          'hF0: begin e_pulse[v][P_IDEX] = 1; m_id[v] = 0; e_tag[v] = "R3"; end
          default: ;
        endcase
      end
      5: if (we) begin
        m_st[v] = 0;
        if (lo == 'h5555) case (d)
          'h10: begin e_pulse[v][P_CHIP] = 1; e_tag[v] = "R4"; end
          'h30: begin e_tag[v] = "R5";
                  if (!pv) begin e_pulse[v][P_SECT] = 1; e_addr[v] = a & ~'hFFF; end end
          'h60: begin e_pulse[v][P_IDEN] = 1; m_id[v] = 1; e_tag[v] = "R6"; end
          'h20: begin e_tag[v] = "R7";
                  if (pv) begin e_pulse[v][P_SDP] = 1; m_sdp[v] = 0; end end
          default: ;
        endcase
      end
      6: if (we) begin
        e_pulse[v][P_PROG] = 1;
        if (pv) begin
          m_base[v] = a & ~(PB - 1); m_cnt[v] = 1; m_tmr[v] = 0; m_st[v] = 7; e_tag[v] = "R10";
        end else begin m_st[v] = 0; e_tag[v] = "R9"; end
      end
      default: begin
        acc = we && ((a >> PW) == (m_base[v] >> PW));
        e_tag[v] = "R11";
        if (acc) begin
          e_pulse[v][P_PROG] = 1; m_cnt[v]++; m_tmr[v] = 0;
          if (m_cnt[v] == PB) begin e_pulse[v][P_COMMIT] = 1; m_st[v] = 0; end
        end else if (m_tmr[v] == TO - 1) begin
          e_pulse[v][P_COMMIT] = 1; m_st[v] = 0;
        end else begin
          m_tmr[v]++;
          if (we) e_tag[v] = "R10";
        end
      end
    endcase
  endtask

  task automatic check_one(input int v);
    bit bad = 0;
    n_vec++;
    if (g_pulse[v] !== e_pulse[v] || g_id[v] !== m_id[v][0]) bad = 1;
    if (e_pulse[v][P_PROG] || e_pulse[v][P_SECT])
      if (g_raddr[v] !== e_addr[v][AW-1:0]) bad = 1;
    if (e_pulse[v][P_PROG] && g_rdata[v] !== e_data[v][7:0]) bad = 1;
    if (e_pulse[v][P_COMMIT] && g_paddr[v] !== m_base[v][AW-1:0]) bad = 1;
    if (bad) begin
      n_bad++;
      $display("FAIL %s variant=%0d actual pulse=%b id=%b addr=%h data=%h page=%h expected pulse=%b id=%0d addr=%h data=%h page=%h",
               e_tag[v], v, g_pulse[v], g_id[v], g_raddr[v], g_rdata[v], g_paddr[v],
               e_pulse[v], m_id[v], e_addr[v][AW-1:0], e_data[v][7:0], m_base[v][AW-1:0]);
    end
  endtask

  task automatic step(input bit we, input int a, input int d);
    @(negedge clk);
    check_one(0); check_one(1);
    wr_en = we; wr_addr = a[AW-1:0]; wr_data = d[7:0];
    model_step(0, we, a & ((1 << AW) - 1), d);
    model_step(1, we, a & ((1 << AW) - 1), d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic cmd3(input int hi, input int c);
    step(1, hi | 'h5555, 'hAA); step(1, hi | 'h2AAA, 'h55); step(1, hi | 'h5555, c);
  endtask

  task automatic cmd6(input int hi, input int c);
    cmd3(0, 'h80); cmd3(hi, c);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    int a, d, pick;
    for (int v = 0; v < 2; v++) begin
      m_st[v] = 0; m_id[v] = 0; m_sdp[v] = 1; m_base[v] = 0; m_cnt[v] = 0; m_tmr[v] = 0;
      e_pulse[v] = '0; e_addr[v] = 0; e_data[v] = 0; e_tag[v] = "R1";
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state, protected page variant ignores plain writes
    idle(2);
    step(1, 'h01234, 'h77); step(1, 'h00400, 'h12);
    // R2 R3: high address bits ignored, ID enter; R8 lone F0 exit
    cmd3('h10000, 'h90); step(1, 'h3ABCD, 'hF0);
    cmd3('h08000, 'h90); cmd3(0, 'hF0);
    // R2: broken sequence gives nothing
    step(1, 'h5555, 'hAA); step(1, 'h2AAA, 'h54); step(1, 'h5555, 'h90);
    step(1, 'h5555, 'hAA); step(1, 'h2AAA, 'h55); step(1, 'h1555, 'h90);
    // R4 R5 R6 R7
    cmd6(0, 'h10); cmd6('h20000, 'h30); cmd6('h18000, 'h30);
    cmd6(0, 'h60); cmd3(0, 'hF0); cmd6(0, 'h20);
    // R9 R10 R11: byte program, full page with commit on the last byte
    cmd3(0, 'hA0); step(1, 'h00345, 'h5A);
    for (int i = 1; i < PB; i++) step(1, 'h00340 + i, 'h20 + i);
    idle(2);
    // R11: write on the expiring cycle restarts the timer; R10 off-page ignored
    cmd3(0, 'hA0); step(1, 'h00100, 'h01);
    idle(TO - 1); step(1, 'h00101, 'h02);
    step(1, 'h00900, 'h03); idle(TO + 1);
    // R12: protection off, plain write opens a page
    step(1, 'h02222, 'h33); idle(TO + 1);
    // random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      pick = $urandom % 4;
      a = ($urandom % 8) << 15;
      a = (pick == 0 || pick == 2) ? (a | 'h5555) : (pick == 1) ? (a | 'h2AAA) : ($urandom % (1 << AW));
      case ($urandom % 12)
        0, 11: d = 'hAA;  1: d = 'h55;  2: d = 'h80;  3: d = 'h90;
        4: d = 'hF0;  5: d = 'hA0;  6: d = 'h10;  7: d = 'h20;
        8: d = 'h30;  9: d = 'h60;  default: d = $urandom % 256;
      endcase
      step(($urandom % 10) < 7, a, d);
    end
    step(0, 0, 0);
    summary();
  end
endmodule